// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. Two register operands and a three-bit condition code come in together with a valid strobe. One shared subtractor produces the four terms every comparison is built from: a zero term, a borrow term, the sign bit and a signed-overflow term. The condition code picks which combination of those terms drives the single `taken` output.

Equality can come from either of two sources. One is the zero term of the subtractor. The other is a NOR-reduction of the bitwise XOR of the operands, which settles sooner because it needs no carry chain. A parameter selects the source. A second parameter places an optional register stage at the output. With that stage enabled, the verdict and `outValid` appear one cycle after `inValid`. With it disabled, the verdict is combinational in the same cycle. Condition codes that name no comparison give a not-taken verdict and raise a flag.

Top module: `branch_verdict`

## Requirements
- R1: Condition code 3'b000 (equal) gives `taken`=1 exactly when `opA` equals `opB`, with either equality source selected by `EQ_FAST`.
- R2: Condition code 3'b001 (not-equal) gives `taken`=1 exactly when `opA` differs from `opB`.
- R3: Condition code 3'b100 (signed less-than) gives `taken`=1 exactly when `opA` < `opB` as two's-complement numbers. This holds where the raw difference has a clear sign bit: minimum negative compared with maximum positive is taken.
- R4: Condition code 3'b101 (signed greater-or-equal) gives `taken`=1 exactly when `opA` >= `opB` as two's-complement numbers.
- R5: Condition code 3'b110 (unsigned less-than) gives `taken`=1 exactly when `opA` < `opB` as unsigned numbers, that is, when `opA - opB` borrows.
- R6: Condition code 3'b111 (unsigned greater-or-equal) gives `taken`=1 exactly when `opA - opB` does not borrow.
- R7: Condition codes 3'b010 and 3'b011 give `taken`=0 and `badCond`=1. Every other code gives `badCond`=0.
- R8: With `PIPE_EN`=1, `outValid` equals `inValid` of the previous cycle, and the verdict belongs to the operands of that cycle. Whenever `outValid` is 0, both `taken` and `badCond` are 0.
- R9: While `rstN` is low and in the first cycle after it rises, `outValid`, `taken` and `badCond` are 0.
- R10: With `PIPE_EN`=0, `outValid`, `taken` and `badCond` follow the inputs in the same cycle with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and condition code are valid |
| opA | input | DATA_W | First operand (minuend) |
| opB | input | DATA_W | Second operand (subtrahend) |
| condSel | input | 3 | Condition code |
| outValid | output | 1 | Verdict is valid |
| taken | output | 1 | Branch taken verdict |
| badCond | output | 1 | Condition code names no comparison |

## Verification
A wrong borrow term flips both unsigned verdicts, and a wrong overflow term flips both signed verdicts. Such a fault shows only for operand pairs that exercise it: the overflow fault needs operands of opposite sign whose difference wraps. Because of that, the minimum, maximum, zero and all-ones corner pairs are swept under every code, alongside random pairs. A fault in the register stage or in valid gating shows at `outValid` or `taken` one cycle after the offending input. A fault in the condition decode shows on the very next verdict for the affected code.

// File: rtl/brv_pkg.sv
package brv_pkg;

  typedef enum logic [2:0] {
    COND_EQ  = 3'b000,
    COND_NE  = 3'b001,
    COND_RS0 = 3'b010,
    COND_RS1 = 3'b011,
    COND_LT  = 3'b100,
    COND_GE  = 3'b101,
    COND_LTU = 3'b110,
    COND_GEU = 3'b111
  } condCode_t;

  // One-hot select strobes from control to datapath
  typedef struct packed {
    logic selEq;
    logic selNe;
    logic selLt;
    logic selGe;
    logic selLtu;
    logic selGeu;
    logic illegal;
  } ctrlStrobes_t;

  typedef struct packed {
    logic isZero;
    logic borrow;
    logic signBit;
    logic sOvf;
  } cmpTerms_t;

endpackage

// File: rtl/brv_ctrl.sv
module brv_ctrl
  import brv_pkg::*;
(
  input  logic [2:0]   condSel,
  output ctrlStrobes_t strobes
);

  condCode_t code;

  always_comb begin
    code = condCode_t'(condSel);
    strobes = '0;
    unique case (code)
      COND_EQ:  strobes.selEq  = 1'b1;
      COND_NE:  strobes.selNe  = 1'b1;
      COND_LT:  strobes.selLt  = 1'b1;
      COND_GE:  strobes.selGe  = 1'b1;
      COND_LTU: strobes.selLtu = 1'b1;
      COND_GEU: strobes.selGeu = 1'b1;
      default:  strobes.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/brv_sub.sv
module brv_sub
  import brv_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit EQ_FAST = 1'b1
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output cmpTerms_t         terms
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   sumExt;
  logic [DATA_W-1:0] diff;
  logic              carryOut;
  logic              eqTerm;

  // A - B as A + ~B + 1 with the carry out kept
  assign sumExt   = {1'b0, opA} + {1'b0, ~opB} + {{DATA_W{1'b0}}, 1'b1};
  assign diff     = sumExt[DATA_W-1:0];
  assign carryOut = sumExt[DATA_W];

  generate
    if (EQ_FAST) begin : g_xorEq
      assign eqTerm = ~|(opA ^ opB);
    end else begin : g_subEq
      assign eqTerm = ~|diff;
    end
  endgenerate

  always_comb begin
    terms.isZero  = eqTerm;
    terms.borrow  = ~carryOut;
    terms.signBit = diff[MSB];
    terms.sOvf    = (opA[MSB] ^ opB[MSB]) & (diff[MSB] ^ opA[MSB]);
  end

endmodule

// File: rtl/brv_dpath.sv
module brv_dpath
  import brv_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit EQ_FAST = 1'b1,
  parameter bit PIPE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  ctrlStrobes_t      strobes,
  output logic              outValid,
  output logic              taken,
  output logic              badCond
);

  cmpTerms_t terms;
  logic      sLess;
  logic      verdict;
  logic      nextTaken;
  logic      nextBad;

  brv_sub #(.DATA_W(DATA_W), .EQ_FAST(EQ_FAST)) sub_i (
    .opA   (opA),
    .opB   (opB),
    .terms (terms)
  );

  assign sLess = terms.signBit ^ terms.sOvf;

  always_comb begin
    verdict = (strobes.selEq  &  terms.isZero)
            | (strobes.selNe  & ~terms.isZero)
            | (strobes.selLt  &  sLess)
            | (strobes.selGe  & ~sLess)
            | (strobes.selLtu &  terms.borrow)
            | (strobes.selGeu & ~terms.borrow);
    nextTaken = inValid & verdict & ~strobes.illegal;
    nextBad   = inValid & strobes.illegal;
  end

  generate
    if (PIPE_EN) begin : g_pipe
      always_ff @(posedge clk) begin
        if (!rstN) begin
          outValid <= 1'b0;
          taken    <= 1'b0;
          badCond  <= 1'b0;
        end else begin
          outValid <= inValid;
          taken    <= nextTaken;
          badCond  <= nextBad;
        end
      end
    end else begin : g_comb
      assign outValid = inValid & rstN;
      assign taken    = nextTaken & rstN;
      assign badCond  = nextBad & rstN;
    end
  endgenerate

endmodule

// File: rtl/branch_verdict.sv
module branch_verdict
  import brv_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit EQ_FAST = 1'b1,
  parameter bit PIPE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [2:0]        condSel,
  output logic              outValid,
  output logic              taken,
  output logic              badCond
);

  ctrlStrobes_t strobes;

  brv_ctrl ctrl_i (
    .condSel (condSel),
    .strobes (strobes)
  );

  brv_dpath #(.DATA_W(DATA_W), .EQ_FAST(EQ_FAST), .PIPE_EN(PIPE_EN)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .outValid (outValid),
    .taken    (taken),
    .badCond  (badCond)
  );

endmodule

// File: rtl/brv_chk.sv
module brv_chk #(
  parameter int DATA_W  = 32,
  parameter bit PIPE_EN = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [2:0]        condSel,
  input logic              outValid,
  input logic              taken,
  input logic              badCond
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!taken && !badCond)); // R8

  AST_BAD_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    badCond |-> !taken); // R7

  generate
    if (PIPE_EN) begin : g_pipeChk
      AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rstN)
        $past(rstN) |-> (outValid == $past(inValid))); // R8

      AST_EQ_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(inValid) && $past(condSel) == 3'b000)
          |-> (taken == ($past(opA) == $past(opB)))); // R1

      AST_SLT_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(inValid) && $past(condSel) == 3'b100)
          |-> (taken == ($signed($past(opA)) < $signed($past(opB))))); // R3

      AST_ULT_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(inValid) && $past(condSel) == 3'b110)
          |-> (taken == ($past(opA) < $past(opB)))); // R5

      AST_RESERVED_FLAG: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rstN) && $past(inValid) && $past(condSel[2:1]) == 2'b01)
          |-> badCond); // R7
    end else begin : g_combChk
      always_comb begin
        if (rstN) begin
          AST_COMB_FOLLOW: assert (outValid == inValid); // R10
        end
      end
    end
  endgenerate

endmodule

bind branch_verdict brv_chk #(.DATA_W(DATA_W), .PIPE_EN(PIPE_EN)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opA      (opA),
  .opB      (opB),
  .condSel  (condSel),
  .outValid (outValid),
  .taken    (taken),
  .badCond  (badCond)
);

// File: tb/branch_verdict_tb_top.sv
`timescale 1ns/1ps
module branch_verdict_tb_top;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [2:0]   condSel = 3'b000;

  logic outValid, taken, badCond;
  logic cValid, cTaken, cBad;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  branch_verdict #(.DATA_W(W), .EQ_FAST(1'b1), .PIPE_EN(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .condSel(condSel), .outValid(outValid), .taken(taken), .badCond(badCond)
  );

  // Second build: subtractor equality, no register stage
  branch_verdict #(.DATA_W(W), .EQ_FAST(1'b0), .PIPE_EN(1'b0)) dutComb_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .condSel(condSel), .outValid(cValid), .taken(cTaken), .badCond(cBad)
  );

  function automatic logic expTaken(input logic [2:0] c, input logic [W-1:0] a,
                                    input logic [W-1:0] b);
    case (c)
      3'b000:  return a == b;
      3'b001:  return a != b;
      3'b100:  return $signed(a) < $signed(b);
      3'b101:  return $signed(a) >= $signed(b);
      3'b110:  return a < b;
      3'b111:  return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string reqOf(input logic [2:0] c);
    case (c)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b100:  return "R3";
      3'b101:  return "R4";
      3'b110:  return "R5";
      3'b111:  return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b opA=%h opB=%h cond=%b", req, act, exp, opA, opB, condSel);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge
  task automatic runOne(input logic [2:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
    logic e;
    logic ill;
    @(negedge clk);
    inValid = 1'b1; condSel = c; opA = a; opB = b;
    e = expTaken(c, a, b);
    ill = (c[2:1] == 2'b01);
    #1;
    check("R10", cTaken, e);
    check("R10", cBad, ill);
    check("R10", cValid, 1'b1);
    @(negedge clk);
    check(reqOf(c), taken, e);
    check("R7", badCond, ill);
    check("R8", outValid, 1'b1);
  endtask

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] corner [5];
    process::self().srandom(32'h5eed_1234);
    corner[0] = {1'b1, {(W-1){1'b0}}};
    corner[1] = {1'b0, {(W-1){1'b1}}};
    corner[2] = '0;
    corner[3] = '1;
    corner[4] = {{(W-1){1'b0}}, 1'b1};

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9", outValid, 1'b0);
    check("R9", taken, 1'b0);
    check("R9", badCond, 1'b0);
    inValid = 1'b1; condSel = 3'b000;
    @(negedge clk);
    check("R9", taken, 1'b0);
    rstN = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    check("R9", outValid, 1'b0);

    // R3: minimum negative vs maximum positive, difference has a clear sign bit
    runOne(3'b100, corner[0], corner[1]);
    runOne(3'b101, corner[0], corner[1]);

    // corner sweep over every code
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          runOne(3'(c), corner[i], corner[j]);

    // constrained random: some pairs forced equal or near
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      a = $urandom();
      case ($urandom_range(0, 3))
        0: b = a;
        1: b = a + 1;
        2: b = a ^ {1'b1, {(W-1){1'b0}}};
        default: b = $urandom();
      endcase
      runOne(3'($urandom_range(0, 7)), a, b);
    end

    // R8: idle input quiets outputs even with an equal pair
    @(negedge clk);
    inValid = 1'b0; condSel = 3'b000; opA = '0; opB = '0;
    @(negedge clk);
    check("R8", outValid, 1'b0);
    check("R8", taken, 1'b0);
    check("R8", badCond, 1'b0);
    // R7 with invalid input: no flag
    condSel = 3'b010;
    @(negedge clk);
    check("R7", badCond, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule